// File: doc/BRIEF.md
# Berger-Coded Self-Checking State Machine

This block is a small Mealy control state machine whose state register carries a separable unidirectional-error code. The nominal state uses the minimum number of bits, with any binary assignment. A check field is appended to it: the binary count of the zero bits in the nominal part. A register whose check field differs from that count is a redundant state, and such a state means a fault has happened.

The next-state network is built only from AND and OR terms. It receives each state bit and each input bit in both true and complemented form, so a single stuck-at fault inside it can only push bits in one direction. Its coded output feeds the state register and the checker in the same cycle. The nominal part and the check part stay separate on the way.

The checker works in two steps. It first recounts the zeros of the nominal part. It then compares that count with the received check bits, using a chain of two-rail cells. The result is a registered two-rail pair, and a sticky error bit records the first bad pair. The example machine has four states. Input bit 0 steps the state up modulo four, input bit 1 steps it down, and when both input bits are equal the state holds.

Top module: `berger_fsm`

## Requirements
- R1: While rst is high at a clock edge, that edge loads state_nom=0 with state_chk=2 (its zero count), err_rail=2'b01 and err_flag=0.
- R2: At each edge the nominal state is updated from the input applied before that edge. in_t=2'b01 gives (s+1) mod 4, in_t=2'b10 gives (s-1) mod 4, and in_t=2'b00 or 2'b11 holds s.
- R3: In every reachable state, state_chk equals the number of zero bits in state_nom, as a 2-bit binary value.
- R4: When the next-state word is a code word, the err_rail captured at that edge is a valid pair (2'b01 or 2'b10), and err_flag stays 0.
- R5: A next-state word whose check field does not equal the zero count of its nominal bits makes the err_rail captured at that same edge 2'b00 or 2'b11. This covers a single bit forced to 0 or 1 in either the nominal part or the check part.
- R6: err_flag is set at the edge that captures an invalid pair. It stays set while later words are valid, and only reset clears it.
- R7: A wrong check field in which bits err in both directions at once (2'b10 replaced by 2'b01) is also flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_t | input | 2 | Primary inputs: bit 0 step up, bit 1 step down |
| state_nom | output | 2 | Registered nominal state bits |
| state_chk | output | 2 | Registered Berger check field |
| err_rail | output | 2 | Registered two-rail checker result; 01 or 10 means no error |
| err_flag | output | 1 | Sticky error indication |

## Verification
A table of input sequences walks the machine forward, backward, across the wrap at both ends, and through both hold codes. These runs show that the transition function is right and that good words never raise the checker. An exhaustive sweep applies every input in every state and confirms, in each case, the next state and that the check field matches the zero count. Stuck-at faults are then forced on each bit of the next-state word, in each state and at each polarity. These runs separate faults that change the word, which must be flagged at that same edge, from faults that leave the word unchanged, which must stay silent. A check field with one bit rising and one bit falling exercises the comparator's bidirectional case. Finally, valid words arriving after a fault show that err_flag stays set until reset.

// File: rtl/berger_pkg.sv
package berger_pkg;

  // Zero count of the low n bits of v.
  function automatic int zeros_of(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) if (!v[i]) c++;
    return c;
  endfunction

  // Example machine: bit0 steps up, bit1 steps down, equal bits hold.
  function automatic int next_of(input int s, input int in, input int ns_w);
    int m;
    int up;
    int dn;
    m  = 1 << ns_w;
    up = in & 1;
    dn = (in >> 1) & 1;
    if (up == 1 && dn == 0) return (s + 1) % m;
    if (dn == 1 && up == 0) return (s + m - 1) % m;
    return s;
  endfunction

  // Full code word {check, nominal} for a state/input combination.
  function automatic logic [31:0] code_of(input int s, input int in, input int ns_w);
    int nx;
    logic [31:0] w;
    nx = next_of(s, in, ns_w);
    w  = 32'(zeros_of(32'(nx), ns_w)) << ns_w;
    w  = w | 32'(nx);
    return w;
  endfunction

endpackage

// File: rtl/berger_ns_logic.sv
module berger_ns_logic #(
  parameter int NS_W = 2,
  parameter int IN_W = 2,
  parameter int CK_W = 2
) (
  input  logic [NS_W-1:0] ps_t,
  input  logic [NS_W-1:0] ps_c,
  input  logic [IN_W-1:0] in_t,
  input  logic [IN_W-1:0] in_c,
  output logic [NS_W-1:0] ns_nom,
  output logic [CK_W-1:0] ns_chk
);
  localparam int LW    = NS_W + IN_W;
  localparam int WW    = NS_W + CK_W;
  localparam int NCOMB = 1 << LW;
  localparam int NST   = 1 << NS_W;

  logic [LW-1:0] lit_t;
  logic [LW-1:0] lit_c;
  logic [WW-1:0] word;

  assign lit_t = {in_t, ps_t};
  assign lit_c = {in_c, ps_c};

  // Sum of products over true/complement rails only: no inverters inside.
  always_comb begin
    logic        mt;
    logic [31:0] cw;
    word = '0;
    for (int k = 0; k < NCOMB; k++) begin
      mt = 1'b1;
      for (int b = 0; b < LW; b++)
        mt = mt & ((((k >> b) & 1) == 1) ? lit_t[b] : lit_c[b]);
      cw = berger_pkg::code_of(k & (NST - 1), k >> NS_W, NS_W);
      for (int j = 0; j < WW; j++)
        if (cw[j]) word[j] = word[j] | mt;
    end
  end

  assign ns_nom = word[NS_W-1:0];
  assign ns_chk = word[WW-1:NS_W];
endmodule

// File: rtl/berger_zero_cnt.sv
module berger_zero_cnt #(
  parameter int W  = 2,
  parameter int CW = 2
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(!v[i]);
  end
endmodule

// File: rtl/berger_rail_cmp.sv
module berger_rail_cmp #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] calc,
  input  logic [CW-1:0] recv,
  output logic [1:0]    pair
);
  // Bit i forms the pair (calc[i], ~recv[i]); valid when the rails differ.
  logic [CW-1:0] rx;
  logic [CW-1:0] ry;

  assign rx[0] = calc[0];
  assign ry[0] = ~recv[0];

  genvar i;
  generate
    for (i = 1; i < CW; i++) begin : g_cell
      logic bx;
      logic by;
      assign bx    = calc[i];
      assign by    = ~recv[i];
      assign rx[i] = (rx[i-1] & bx) | (ry[i-1] & by);
      assign ry[i] = (rx[i-1] & by) | (ry[i-1] & bx);
    end
  endgenerate

  assign pair = {rx[CW-1], ry[CW-1]};
endmodule

// File: rtl/berger_state_reg.sv
module berger_state_reg #(
  parameter int               NS_W    = 2,
  parameter int               CK_W    = 2,
  parameter logic [NS_W-1:0]  RST_NOM = '0,
  parameter logic [CK_W-1:0]  RST_CHK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NS_W-1:0] d_nom,
  input  logic [CK_W-1:0] d_chk,
  input  logic [1:0]      rail_in,
  output logic [NS_W-1:0] q_nom,
  output logic [NS_W-1:0] qn_nom,
  output logic [CK_W-1:0] q_chk,
  output logic [1:0]      rail_q,
  output logic            flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_nom  <= RST_NOM;
      qn_nom <= ~RST_NOM;
      q_chk  <= RST_CHK;
      rail_q <= 2'b01;
      flag   <= 1'b0;
    end else begin
      q_nom  <= d_nom;
      qn_nom <= ~d_nom;
      q_chk  <= d_chk;
      rail_q <= rail_in;
      flag   <= flag | ~(rail_in[1] ^ rail_in[0]);
    end
  end

  AST_RST_LOAD: assert property (@(posedge clk)
    rst |=> (q_nom == RST_NOM && q_chk == RST_CHK && rail_q == 2'b01 && !flag)); // R1

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    flag |=> flag); // R6

  AST_FLAG_ON_BAD: assert property (@(posedge clk) disable iff (rst)
    !(rail_q[1] ^ rail_q[0]) |-> flag); // R6
endmodule

// File: rtl/berger_fsm.sv
module berger_fsm #(
  parameter int              NS_W    = 2,
  parameter int              IN_W    = 2,
  parameter logic [NS_W-1:0] RST_NOM = '0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [IN_W-1:0]                  in_t,
  output logic [NS_W-1:0]                  state_nom,
  output logic [$clog2(NS_W+1)-1:0]        state_chk,
  output logic [1:0]                       err_rail,
  output logic                             err_flag
);
  localparam int              CK_W    = $clog2(NS_W + 1);
  localparam int              WW      = NS_W + CK_W;
  localparam logic [CK_W-1:0] RST_CHK = CK_W'(berger_pkg::zeros_of(32'(RST_NOM), NS_W));

  logic [NS_W-1:0] ps_c;
  logic [NS_W-1:0] nx_nom;
  logic [CK_W-1:0] nx_chk;
  logic [WW-1:0]   ns_word;
  logic [CK_W-1:0] calc_chk;
  logic [1:0]      pair;

  berger_ns_logic #(.NS_W(NS_W), .IN_W(IN_W), .CK_W(CK_W)) u_ns (
    .ps_t(state_nom), .ps_c(ps_c), .in_t(in_t), .in_c(~in_t),
    .ns_nom(nx_nom), .ns_chk(nx_chk)
  );

  // Single coded word feeding register and checker alike.
  assign ns_word = {nx_chk, nx_nom};

  berger_zero_cnt #(.W(NS_W), .CW(CK_W)) u_zc (
    .v(ns_word[NS_W-1:0]), .cnt(calc_chk)
  );

  berger_rail_cmp #(.CW(CK_W)) u_cmp (
    .calc(calc_chk), .recv(ns_word[WW-1:NS_W]), .pair(pair)
  );

  berger_state_reg #(.NS_W(NS_W), .CK_W(CK_W), .RST_NOM(RST_NOM), .RST_CHK(RST_CHK)) u_reg (
    .clk(clk), .rst(rst),
    .d_nom(ns_word[NS_W-1:0]), .d_chk(ns_word[WW-1:NS_W]), .rail_in(pair),
    .q_nom(state_nom), .qn_nom(ps_c), .q_chk(state_chk),
    .rail_q(err_rail), .flag(err_flag)
  );

  AST_GOOD_RAIL_CODEWORD: assert property (@(posedge clk) disable iff (rst)
    (err_rail[1] ^ err_rail[0]) |->
      (int'(state_chk) == berger_pkg::zeros_of(32'(state_nom), NS_W))); // R5
endmodule

// File: tb/test_berger_fsm.sv
module test_berger_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] in_t = 2'b00;
  logic [1:0] state_nom;
  logic [1:0] state_chk;
  logic [1:0] err_rail;
  logic       err_flag;
  logic [3:0] fval;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  berger_fsm i_berger_fsm (
    .clk(clk), .rst(rst), .in_t(in_t),
    .state_nom(state_nom), .state_chk(state_chk),
    .err_rail(err_rail), .err_flag(err_flag)
  );

  // Each entry: {input[1:0], expected nominal state after the edge}
  localparam logic [3:0] VEC [12] = '{
    {2'b01, 2'd1}, {2'b01, 2'd2}, {2'b01, 2'd3}, {2'b01, 2'd0},
    {2'b10, 2'd3}, {2'b10, 2'd2}, {2'b00, 2'd2}, {2'b11, 2'd2},
    {2'b01, 2'd3}, {2'b10, 2'd2}, {2'b10, 2'd1}, {2'b10, 2'd0}
  };

  function automatic int zc(input logic [1:0] v);
    return (v[0] ? 0 : 1) + (v[1] ? 0 : 1);
  endfunction

  function automatic logic [1:0] model(input logic [1:0] s, input logic [1:0] in);
    if (in == 2'b01) return s + 2'd1;
    if (in == 2'b10) return s - 2'd1;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] v);
    in_t = v;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    rst = 1'b0;
  endtask

  task automatic goto_state(input int s);
    do_reset();
    for (int k = 0; k < s; k++) step(2'b01);
  endtask

  initial begin
    @(posedge clk);
    #2;
    do_reset();
    // R1 reset state
    chk(state_nom == 2'd0, "R1 nom", int'(state_nom), 0);
    chk(state_chk == 2'd2, "R1 chk", int'(state_chk), 2);
    chk(err_rail == 2'b01, "R1 rail", int'(err_rail), 1);
    chk(err_flag == 1'b0, "R1 flag", int'(err_flag), 0);

    // R2 table walk
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][3:2]);
      chk(state_nom == VEC[i][1:0], "R2 table", int'(state_nom), int'(VEC[i][1:0]));
      chk(int'(state_chk) == zc(state_nom), "R3 table", int'(state_chk), zc(state_nom));
      chk((err_rail[1] ^ err_rail[0]) && !err_flag, "R4 table", int'({err_flag, err_rail}), 1);
    end

    // R2/R3/R4 exhaustive sweep
    for (int s = 0; s < 4; s++) begin
      for (int in = 0; in < 4; in++) begin
        logic [1:0] e;
        goto_state(s);
        e = model(2'(s), 2'(in));
        step(2'(in));
        chk(state_nom == e, "R2 sweep", int'(state_nom), int'(e));
        chk(int'(state_chk) == zc(e), "R3 sweep", int'(state_chk), zc(e));
        chk((err_rail[1] ^ err_rail[0]) && !err_flag, "R4 sweep", int'({err_flag, err_rail}), 1);
      end
    end

    // R5 single stuck-at on each next-state bit, input held at 00
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 4; b++) begin
        for (int sv = 0; sv < 2; sv++) begin
          logic [3:0] good;
          goto_state(s);
          in_t = 2'b00;
          good = {2'(zc(2'(s))), 2'(s)};
          fval = good;
          fval[b] = sv[0];
          force i_berger_fsm.ns_word = fval;
          @(posedge clk);
          #2;
          release i_berger_fsm.ns_word;
          if (fval != good) begin
            chk(!(err_rail[1] ^ err_rail[0]), "R5 stuck", int'(err_rail), 0);
            chk(err_flag == 1'b1, "R6 set", int'(err_flag), 1);
          end else begin
            chk((err_rail[1] ^ err_rail[0]) && !err_flag, "R4 benign", int'({err_flag, err_rail}), 1);
          end
        end
      end
    end

    // R7 bidirectional check-field error
    goto_state(0);
    in_t = 2'b00;
    fval = 4'b0100;
    force i_berger_fsm.ns_word = fval;
    @(posedge clk);
    #2;
    release i_berger_fsm.ns_word;
    chk(!(err_rail[1] ^ err_rail[0]), "R7 rail", int'(err_rail), 0);
    chk(err_flag == 1'b1, "R7 flag", int'(err_flag), 1);

    // R6 flag stays set over valid words, reset clears it
    step(2'b01);
    step(2'b01);
    chk(err_rail[1] ^ err_rail[0], "R6 rail back valid", int'(err_rail), 1);
    chk(err_flag == 1'b1, "R6 sticky", int'(err_flag), 1);
    do_reset();
    chk(err_flag == 1'b0, "R6 reset clears", int'(err_flag), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule